// File: doc/BRIEF.md
# Strobe-Locked Output Tick Generator

This block turns a slow, irregular reference strobe into a steady, much faster output tick. The strobe is a one-cycle pulse in the local clock domain, nominally 100 times a second. It is produced by software, so each edge may land up to about half a millisecond early or late, and now and then one never arrives. From a 50 MHz local clock the block produces an 8 kHz tick. Over the long term it emits exactly the nominal number of ticks (80 by default) per reference period, and it does not let single late or early strobes pull the output rate around.

The tick comes from a phase accumulator whose increment is trimmed by a slow proportional-plus-integral loop. On each strobe the loop counts how many ticks fell since the previous strobe and compares that count with the expected number. A timeout marks a strobe as missing. In that case the increment is held and the measurement window is stretched instead of restarted. The loop starts with a fast acquiring gain. After a run of exact periods it moves to a slow holding gain, keeping the increment it has reached. A lock flag is raised in the holding mode and is dropped, together with a return to acquiring, after a run of grossly wrong periods.

Top module: `refsync_tick_gen`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the tick, lock flag and mode indicator are 0. A mode value of 0 means acquiring and 1 means holding.
- R2: The nominal increment is floor(TICKS·2^ACC_W / REF_PERIOD). A one-cycle tick marks each accumulator overflow, so with the increment at its nominal value the ticks are evenly spaced (64 clocks apart when ACC_W=16, REF_PERIOD=512, TICKS=8), and a tick is never high in two consecutive cycles.
- R3: Each strobe closes a window. The window starts in the cycle after the previous strobe and includes the strobe's own cycle. The period error is the number of ticks in the window minus TICKS times (missing periods + 1). The first strobe after reset only opens a window and produces no update.
- R4: In acquiring mode the correction is (error·STEP) shifted right by ACQ_SHIFT, rounded toward zero, where STEP = floor(2^ACC_W / REF_PERIOD). The integral gains the correction and is limited to ±NOM/4. The new increment is NOM − integral − correction, limited to NOM ± NOM/2. In the bench configuration an error of +1 moves the increment from 1024 to 1008, which gives tick spacings of 65 or 66 clocks.
- R5: In holding mode the same rule applies with HOLD_SHIFT. In the bench configuration, errors of ±1 and +3 leave the increment, and so the 64-clock spacing, unchanged.
- R6: The mode changes to holding after LOCK_RUN consecutive updates in acquiring mode whose error magnitude is at most ENTER_TOL (default 0). The mode changes only on an update, and the increment reached is carried over, so the tick spacing is unchanged across the switch.
- R7: The lock flag rises on the first update in holding mode whose error magnitude is at most UNLOCK_TOL (default 2). The flag is never high outside holding mode.
- R8: If UNLOCK_TOL is exceeded on UNLOCK_RUN consecutive updates in holding mode, the lock flag clears and the mode returns to acquiring. Fewer such updates leave both unchanged.
- R9: When no strobe arrives within 3·REF_PERIOD/2 of the last one, the period is counted as missing. Further periods are counted every REF_PERIOD after that. The tick count is not reset. The increment does not change between updates, and the next strobe compares its window with TICKS times (missing + 1).
- R10: The missing-period count saturates at MAX_GAP. A strobe that arrives with the count saturated only restarts the window and produces no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local time base |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_strobe | input | 1 | One-cycle reference pulse |
| tick_o | output | 1 | One-cycle output tick |
| locked_o | output | 1 | Lock flag |
| hold_mode_o | output | 1 | Mode indicator, 1 when holding |

## Verification
The bench builds the block with a 16-bit accumulator, a 512-clock reference period and 8 ticks per period. With these values the nominal increment and the error step are exact powers of two, so every tick lands on a 64-clock grid and the tick count in any window can be worked out by hand. The small period also puts the whole sequence within a few tens of thousands of cycles: the full run of exact periods into holding mode, jittered windows, a single missing strobe, a silence long enough to saturate the missing-period count, a run of bad periods that unlocks the loop, and the acquiring-gain step that follows.

// File: rtl/rsl_pkg.sv
// Shared types for the strobe-locked tick generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rsl_pkg;

    // Loop operating mode: fast gain while acquiring, slow gain while holding.
    typedef enum logic {
        MODE_ACQ  = 1'b0,
        MODE_HOLD = 1'b1
    } loop_mode_e;

endpackage

// File: rtl/rsl_nco.sv
// Phase accumulator that emits a one-cycle tick on every overflow.
// Assumes inc stays below half the accumulator range, so ticks never touch.
module rsl_nco #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   acc_sum;

    // Widened sum so the carry out becomes the tick.
    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, inc};
    end

    // Advance the phase and register the overflow as the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= acc_sum[ACC_W-1:0];
            tick <= acc_sum[ACC_W];
        end
    end

endmodule

// File: rtl/rsl_period_meter.sv
// Counts output ticks between reference strobes and reports the period error.
// A strobe that is 3/2 of a period late is counted as missing, and the window
// stretches by one period for each missing strobe. Assumes the strobe is a
// single-cycle pulse in the clk domain.
module rsl_period_meter #(
    parameter int unsigned REF_PERIOD = 500000,
    parameter int unsigned TICKS      = 80,
    parameter int unsigned MAX_GAP    = 4,
    parameter int unsigned ERR_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic                    tick,
    output logic                    upd_valid,
    output logic signed [ERR_W-1:0] upd_err
);

    localparam int unsigned TIMEOUT = REF_PERIOD + REF_PERIOD / 2;
    localparam int unsigned TMR_W   = $clog2(TIMEOUT + 1);
    localparam int unsigned GAP_W   = $clog2(MAX_GAP + 1);
    localparam int unsigned CNT_MAX = TICKS * (MAX_GAP + 2);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    logic [TMR_W-1:0] timer;
    logic [GAP_W-1:0] gaps;
    logic [CNT_W-1:0] cnt;
    logic             primed;
    logic [CNT_W:0]   measured;
    logic [CNT_W:0]   expected;
    logic signed [ERR_W-1:0] err_now;

    // Ticks in the closing window and the count the window should hold.
    always_comb begin
        measured = {1'b0, cnt} + {{CNT_W{1'b0}}, tick};
        expected = (CNT_W + 1)'(TICKS * (32'(gaps) + 32'd1));
        err_now  = ERR_W'(measured) - ERR_W'(expected);
    end

    // Window bookkeeping: tick count, timeout timer, missing-period count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer     <= '0;
            gaps      <= '0;
            cnt       <= '0;
            primed    <= 1'b0;
            upd_valid <= 1'b0;
            upd_err   <= '0;
        end else begin
            upd_valid <= 1'b0;
            if (strobe) begin
                if (primed && (gaps < GAP_W'(MAX_GAP))) begin
                    upd_valid <= 1'b1;
                    upd_err   <= err_now;
                end
                primed <= 1'b1;
                gaps   <= '0;
                timer  <= '0;
                cnt    <= '0;
            end else begin
                if (tick && (cnt != CNT_W'(CNT_MAX))) begin
                    cnt <= cnt + 1'b1;
                end
                if (primed) begin
                    if (timer == TMR_W'(TIMEOUT)) begin
                        timer <= TMR_W'(TIMEOUT - REF_PERIOD + 1);
                        if (gaps < GAP_W'(MAX_GAP)) begin
                            gaps <= gaps + 1'b1;
                        end
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rsl_loop_filter.sv
// Proportional-plus-integral filter that turns each period error into a new
// accumulator increment. The gain shift follows the loop mode, and the
// integral is kept across mode changes. Assumes NOM_INC*3/2 fits in ACC_W bits.
module rsl_loop_filter
    import rsl_pkg::*;
#(
    parameter int unsigned     ACC_W      = 32,
    parameter int unsigned     ERR_W      = 12,
    parameter logic [ACC_W-1:0] NOM_INC   = '0,
    parameter logic [ACC_W-1:0] STEP      = '0,
    parameter int unsigned     ACQ_SHIFT  = 4,
    parameter int unsigned     HOLD_SHIFT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_valid,
    input  logic signed [ERR_W-1:0] upd_err,
    input  loop_mode_e              mode,
    output logic [ACC_W-1:0]        inc
);

    localparam int unsigned SUM_W = ACC_W + ERR_W + 2;
    localparam logic signed [SUM_W-1:0] NOM_S   = SUM_W'(NOM_INC);
    localparam logic signed [SUM_W-1:0] INT_LIM = SUM_W'(NOM_INC / 4);
    localparam logic signed [SUM_W-1:0] INC_LO  = NOM_S - SUM_W'(NOM_INC / 2);
    localparam logic signed [SUM_W-1:0] INC_HI  = NOM_S + SUM_W'(NOM_INC / 2);

    // Arithmetic shift that rounds toward zero, so small errors of either sign vanish.
    function automatic logic signed [SUM_W-1:0] shr_sym(
        input logic signed [SUM_W-1:0] v,
        input int unsigned             sh
    );
        if (v < 0) begin
            return -((-v) >>> sh);
        end
        return v >>> sh;
    endfunction

    logic signed [SUM_W-1:0] integ;
    logic signed [SUM_W-1:0] scaled;
    logic signed [SUM_W-1:0] corr;
    logic signed [SUM_W-1:0] integ_raw;
    logic signed [SUM_W-1:0] integ_nx;
    logic signed [SUM_W-1:0] inc_raw;
    logic signed [SUM_W-1:0] inc_nx;
    logic [ACC_W-1:0]        inc_q;
    int unsigned             gain_sh;

    // Scale the error, apply the mode gain, and form clamped integral and increment.
    always_comb begin
        gain_sh   = (mode == MODE_HOLD) ? HOLD_SHIFT : ACQ_SHIFT;
        scaled    = SUM_W'(upd_err) * $signed(SUM_W'(STEP));
        corr      = shr_sym(scaled, gain_sh);
        integ_raw = integ + corr;
        if (integ_raw > INT_LIM) begin
            integ_nx = INT_LIM;
        end else if (integ_raw < -INT_LIM) begin
            integ_nx = -INT_LIM;
        end else begin
            integ_nx = integ_raw;
        end
        inc_raw = NOM_S - integ_nx - corr;
        if (inc_raw > INC_HI) begin
            inc_nx = INC_HI;
        end else if (inc_raw < INC_LO) begin
            inc_nx = INC_LO;
        end else begin
            inc_nx = inc_raw;
        end
    end

    // Commit integral and increment only when a period measurement arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            inc_q <= NOM_INC;
        end else if (upd_valid) begin
            integ <= integ_nx;
            inc_q <= ACC_W'(inc_nx);
        end
    end

    assign inc = inc_q;

endmodule

// File: rtl/rsl_lock_ctrl.sv
// Mode and lock supervisor. It moves to holding after a run of exact periods,
// raises lock on a good period while holding, and drops back to acquiring after
// a run of bad periods. Assumes LOCK_RUN and UNLOCK_RUN are at least 1.
module rsl_lock_ctrl
    import rsl_pkg::*;
#(
    parameter int unsigned ERR_W      = 12,
    parameter int unsigned LOCK_RUN   = 16,
    parameter int unsigned UNLOCK_RUN = 4,
    parameter int unsigned ENTER_TOL  = 0,
    parameter int unsigned UNLOCK_TOL = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_valid,
    input  logic signed [ERR_W-1:0] upd_err,
    output loop_mode_e              mode,
    output logic                    lock
);

    localparam int unsigned GOOD_W = $clog2(LOCK_RUN + 1);
    localparam int unsigned BAD_W  = $clog2(UNLOCK_RUN + 1);

    logic [ERR_W-1:0]  err_mag;
    logic [GOOD_W-1:0] good_run;
    logic [BAD_W-1:0]  bad_run;

    // Magnitude of the period error.
    always_comb begin
        err_mag = (upd_err < 0) ? ERR_W'(-upd_err) : ERR_W'(upd_err);
    end

    // Run counters and mode/lock transitions, evaluated once per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_ACQ;
            lock     <= 1'b0;
            good_run <= '0;
            bad_run  <= '0;
        end else if (upd_valid) begin
            if (mode == MODE_ACQ) begin
                lock    <= 1'b0;
                bad_run <= '0;
                if (err_mag <= ERR_W'(ENTER_TOL)) begin
                    if (good_run == GOOD_W'(LOCK_RUN - 1)) begin
                        mode     <= MODE_HOLD;
                        good_run <= '0;
                    end else begin
                        good_run <= good_run + 1'b1;
                    end
                end else begin
                    good_run <= '0;
                end
            end else begin
                if (err_mag > ERR_W'(UNLOCK_TOL)) begin
                    if (bad_run == BAD_W'(UNLOCK_RUN - 1)) begin
                        mode    <= MODE_ACQ;
                        lock    <= 1'b0;
                        bad_run <= '0;
                    end else begin
                        bad_run <= bad_run + 1'b1;
                    end
                end else begin
                    bad_run <= '0;
                    lock    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/refsync_tick_gen.sv
// Top of the strobe-locked tick generator: period meter, loop filter,
// lock supervisor and phase accumulator. Assumes TICKS/REF_PERIOD is below 1/3,
// so the clamped increment stays under half the accumulator range.
module refsync_tick_gen
    import rsl_pkg::*;
#(
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned REF_PERIOD = 500000,
    parameter int unsigned TICKS      = 80,
    parameter int unsigned MAX_GAP    = 4,
    parameter int unsigned ACQ_SHIFT  = 4,
    parameter int unsigned HOLD_SHIFT = 10,
    parameter int unsigned LOCK_RUN   = 16,
    parameter int unsigned UNLOCK_RUN = 4,
    parameter int unsigned ENTER_TOL  = 0,
    parameter int unsigned UNLOCK_TOL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_strobe,
    output logic tick_o,
    output logic locked_o,
    output logic hold_mode_o
);

    localparam logic [ACC_W-1:0] NOM_INC =
        ACC_W'((64'(TICKS) << ACC_W) / 64'(REF_PERIOD));
    localparam logic [ACC_W-1:0] STEP =
        ACC_W'((64'd1 << ACC_W) / 64'(REF_PERIOD));
    localparam int unsigned CNT_W = $clog2(TICKS * (MAX_GAP + 2) + 1);
    localparam int unsigned ERR_W = CNT_W + 2;

    logic                    upd_valid_w;
    logic signed [ERR_W-1:0] upd_err_w;
    logic [ACC_W-1:0]        inc_w;
    loop_mode_e              mode_w;
    logic                    lock_w;
    logic                    tick_w;

    rsl_period_meter #(
        .REF_PERIOD (REF_PERIOD),
        .TICKS      (TICKS),
        .MAX_GAP    (MAX_GAP),
        .ERR_W      (ERR_W)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (ref_strobe),
        .tick      (tick_w),
        .upd_valid (upd_valid_w),
        .upd_err   (upd_err_w)
    );

    rsl_loop_filter #(
        .ACC_W      (ACC_W),
        .ERR_W      (ERR_W),
        .NOM_INC    (NOM_INC),
        .STEP       (STEP),
        .ACQ_SHIFT  (ACQ_SHIFT),
        .HOLD_SHIFT (HOLD_SHIFT)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid_w),
        .upd_err   (upd_err_w),
        .mode      (mode_w),
        .inc       (inc_w)
    );

    rsl_lock_ctrl #(
        .ERR_W      (ERR_W),
        .LOCK_RUN   (LOCK_RUN),
        .UNLOCK_RUN (UNLOCK_RUN),
        .ENTER_TOL  (ENTER_TOL),
        .UNLOCK_TOL (UNLOCK_TOL)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid_w),
        .upd_err   (upd_err_w),
        .mode      (mode_w),
        .lock      (lock_w)
    );

    rsl_nco #(
        .ACC_W (ACC_W)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_w),
        .tick  (tick_w)
    );

    assign tick_o      = tick_w;
    assign locked_o    = lock_w;
    assign hold_mode_o = (mode_w == MODE_HOLD);

endmodule

// File: rtl/refsync_tick_gen_chk.sv
// Property checker for the strobe-locked tick generator, bound to the top.
// Assumes the strobe is a one-cycle pulse.
module refsync_tick_gen_chk #(
    parameter int unsigned ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_strobe,
    input logic             tick_o,
    input logic             locked_o,
    input logic             hold_mode_o,
    input logic             upd_valid,
    input logic [ACC_W-1:0] inc
);

    // R2: a tick lasts exactly one cycle
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R3: an update can only follow a strobe
    assert_update_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(ref_strobe));

    // R9: the increment holds between updates
    assert_inc_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(inc));

    // R6: the mode moves only on an update
    assert_mode_on_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode_o != $past(hold_mode_o)) |-> $past(upd_valid));

    // R7: lock only while holding
    assert_lock_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> hold_mode_o);

    // R7: lock rises only from a cycle already in holding mode
    assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(hold_mode_o));

endmodule

bind refsync_tick_gen refsync_tick_gen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_strobe  (ref_strobe),
    .tick_o      (tick_o),
    .locked_o    (locked_o),
    .hold_mode_o (hold_mode_o),
    .upd_valid   (upd_valid_w),
    .inc         (inc_w)
);

// File: tb/refsync_tick_gen_bench.sv
// Bench for the strobe-locked tick generator in a small exact configuration:
// 16-bit accumulator, 512-clock reference period, 8 ticks per period (64-clock grid).
module refsync_tick_gen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_strobe = 1'b0;
    logic tick_o;
    logic locked_o;
    logic hold_mode_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_tick = 0;
    int last_gap = 0;
    int tick_total = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    refsync_tick_gen #(
        .ACC_W      (16),
        .REF_PERIOD (512),
        .TICKS      (8),
        .MAX_GAP    (4)
    ) u_refsync_tick_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_strobe  (ref_strobe),
        .tick_o      (tick_o),
        .locked_o    (locked_o),
        .hold_mode_o (hold_mode_o)
    );

    // Tick monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tick_o) begin
            last_gap   = cyc - last_tick;
            last_tick  = cyc;
            tick_total = tick_total + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe now, then wait so the next strobe falls exactly n cycles later.
    task automatic strobe_then(input int n);
        ref_strobe = 1'b1;
        @(negedge clk);
        ref_strobe = 1'b0;
        idle(n - 1);
    endtask

    initial begin
        idle(5);
        check(tick_o == 1'b0 && locked_o == 1'b0 && hold_mode_o == 1'b0,
              "R1 outputs in reset", {tick_o, locked_o, hold_mode_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick_o == 1'b0, "R1 tick after release", tick_o, 0);
        check(locked_o == 1'b0 && hold_mode_o == 1'b0, "R1 lock/mode after release",
              {locked_o, hold_mode_o}, 0);

        // R2: free-running nominal spacing and rate
        idle(1000);
        check(last_gap == 64, "R2 nominal spacing", last_gap, 64);
        begin
            int t0;
            t0 = tick_total;
            idle(640);
            check(tick_total - t0 == 10, "R2 ticks in 640 clocks", tick_total - t0, 10);
        end

        // R3/R6/R7: exact periods; first strobe only opens a window
        for (int k = 1; k <= 18; k++) begin
            strobe_then(512);
            if (k == 16) check(hold_mode_o == 1'b0, "R3 R6 still acquiring after 15 updates", hold_mode_o, 0);
            if (k == 17) begin
                check(hold_mode_o == 1'b1, "R6 holding after 16 exact updates", hold_mode_o, 1);
                check(locked_o == 1'b0, "R7 no lock on entry update", locked_o, 0);
            end
            if (k == 18) begin
                check(locked_o == 1'b1, "R7 lock on first good hold update", locked_o, 1);
                check(last_gap == 64, "R6 spacing kept across switch", last_gap, 64);
            end
        end

        // R5: jittered windows (+-1 tick) in holding mode
        for (int j = 0; j < 3; j++) begin
            strobe_then(576);
            strobe_then(448);
        end
        check(locked_o == 1'b1 && hold_mode_o == 1'b1, "R5 lock kept under jitter",
              {locked_o, hold_mode_o}, 3);
        check(last_gap == 64, "R5 hold gain ignores +-1", last_gap, 64);

        // R9: one missing strobe
        strobe_then(1024);
        strobe_then(512);
        check(locked_o == 1'b1, "R9 lock kept over missing strobe", locked_o, 1);
        strobe_then(512);
        check(last_gap == 64, "R9 spacing after missing strobe", last_gap, 64);

        // R10: silence long enough to saturate the missing count
        strobe_then(3000);
        check(locked_o == 1'b1 && last_gap == 64, "R9 held through silence",
              last_gap, 64);
        strobe_then(704);
        strobe_then(704);
        strobe_then(704);
        strobe_then(704);
        check(locked_o == 1'b1 && hold_mode_o == 1'b1, "R10 R8 restart strobe not counted, 3 bad",
              {locked_o, hold_mode_o}, 3);
        strobe_then(576);
        check(locked_o == 1'b0, "R8 lock cleared after 4 bad", locked_o, 0);
        check(hold_mode_o == 1'b0, "R8 back to acquiring", hold_mode_o, 0);
        check(last_gap == 64, "R5 hold gain ignores +3", last_gap, 64);

        // R4: one +1 update in acquiring mode, then no strobes
        strobe_then(300);
        check(last_gap == 65 || last_gap == 66, "R4 acquire step to 1008", last_gap, 65);
        idle(2000);
        check(last_gap == 65 || last_gap == 66, "R9 increment held across timeouts", last_gap, 65);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule